// File: doc/BRIEF.md
# Credit-Gated Flit Link with CRC Retry

This block is a matched sender and receiver for a single point-to-point link that carries fixed 80-bit flits. On the sending side, 72-bit payload words arrive through a valid/ready handshake. An 8-bit CRC is appended to each one, and the flit goes onto the link only while the sender holds at least one credit. Every flit also carries a 4-bit sequence number beside it. The sender keeps each payload in a 16-entry replay store until the receiver acknowledges it.

The receiver recomputes the CRC on every arriving flit. It delivers clean, in-order payloads through a small buffer with a valid/ready output, and it returns one credit for each flit slot it gives back. A slot is given back either when a buffered payload is taken or when an arriving flit is thrown away. On a CRC mismatch, the receiver raises a retry request that names the sequence number it expected. The sender then rewinds to that flit and resends it together with everything it sent after it. Until the expected flit arrives intact, the receiver drops all other traffic.

An input mask is XORed onto the flit between the two halves. It models line noise, so the error path can be exercised at the ports.

Top module: `flit_link`

## Requirements
- R1: Every flit on the link has the payload in bits [79:8] and a CRC in bits [7:0]. The CRC uses polynomial x^8+x^2+x+1 with a zero initial value and is computed over payload bit 71 down to bit 0.
- R2: After reset, the credit count equals CREDITS (default 4), `link_vld` and `out_vld` are low, and `in_rdy` is high.
- R3: When the credit count is zero, no flit, new or replayed, appears on the link in the next cycle, and `in_rdy` is low.
- R4: The credit count in the next cycle equals the current count, plus the current `cr_ret` value, minus one if a flit is launched. A return and a send in the same cycle therefore leave the count unchanged, and the count never exceeds CREDITS.
- R5: A flit that fails the CRC check raises `retry_vld` in the following cycle, with `retry_seq` set to the expected sequence number. `retry_vld` is never raised without a preceding corrupted flit.
- R6: The first flit launched after a retry request carries the requested sequence number. From there, flits are resent in ascending order.
- R7: The delivered payload stream equals the accepted input stream, exactly once each and in order, whatever errors are injected.
- R8: Sequence numbers increase by one modulo 16 per launched flit, except at a rewind. `in_rdy` is low while a retry request is visible, and no more than 16 flits are ever unacknowledged.
- R9: While `out_vld` is high and `out_rdy` is low, `out_vld` stays high and `out_data` holds its value.
- R10: Dropped flits return their credit just as delivered ones do, so an idle drained link returns to CREDITS credits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Payload word offered |
| in_data | input | 72 | Payload word |
| in_rdy | output | 1 | Payload word accepted this cycle when high with in_vld |
| chan_flip | input | 80 | Bit mask XORed onto the flit in transit |
| link_vld | output | 1 | Flit launched by the sender this cycle |
| link_seq | output | 4 | Sequence number of the launched flit |
| link_flit | output | 80 | Launched flit before the noise mask |
| credits | output | 3 | Sender credit count |
| cr_ret | output | 2 | Credits returned by the receiver this cycle |
| retry_vld | output | 1 | Retry request from the receiver |
| retry_seq | output | 4 | Sequence number to resend from |
| out_vld | output | 1 | Delivered payload available |
| out_data | output | 72 | Delivered payload |
| out_rdy | input | 1 | Consumer takes the delivered payload |

## Verification
The bench goes after four corner cases. The first is credit exhaustion with a stalled consumer: a sender that ignored a zero count would launch a fifth flit. The second is a send coinciding with a credit return: an accounting slip would drift the count. The third is a single-bit flip on a flit, including bits of the CRC field. A rewind that restarted at the wrong flit, skipped later flits or left the receiver in the discard state would duplicate, lose or stall payloads in the delivered stream. The fourth is the drain after errors: forgetting the credit for discarded flits would leave the link short of credits and eventually deadlock it.

// File: rtl/flit_link_pkg.sv
package flit_link_pkg;

  localparam int PAY_W  = 72;
  localparam int CRC_W  = 8;
  localparam int FLIT_W = PAY_W + CRC_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  // Serial CRC, payload MSB first, zero seed, unrolled into one cycle.
  function automatic logic [CRC_W-1:0] crc_of(input logic [PAY_W-1:0] pay);
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = '0;
    for (int i = PAY_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ pay[i];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return acc;
  endfunction

endpackage

// File: rtl/flit_tx.sv
module flit_tx
  import flit_link_pkg::*;
#(
  parameter int CREDITS = 4,
  parameter int SEQ_W   = 4,
  parameter int CW      = $clog2(CREDITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [PAY_W-1:0]  in_data,
  output logic              in_rdy,
  input  logic              ack_vld,
  input  logic              retry_vld,
  input  logic [SEQ_W-1:0]  retry_seq,
  input  logic [1:0]        cr_ret,
  output logic              link_vld,
  output logic [SEQ_W-1:0]  link_seq,
  output logic [FLIT_W-1:0] link_flit,
  output logic [CW-1:0]     credits
);

  localparam int DEPTH = 1 << SEQ_W;
  localparam int PW    = SEQ_W + 1;

  logic [PW-1:0]    wr_ptr, wr_ptr_n;
  logic [PW-1:0]    snd_ptr, snd_ptr_n;
  logic [PW-1:0]    ack_ptr, ack_ptr_n;
  logic [CW-1:0]    cred, cred_n;
  logic [PAY_W-1:0] rbuf [DEPTH];

  logic [PW-1:0]    inflight;
  logic             replaying, can_go, snd_new, snd_old, send;
  logic [PAY_W-1:0] tx_pay;

  always_comb begin
    inflight  = wr_ptr - ack_ptr;
    replaying = (snd_ptr != wr_ptr);
    can_go    = !retry_vld && (cred != '0);
    in_rdy    = can_go && !replaying && (inflight < PW'(DEPTH));
    snd_new   = in_vld && in_rdy;
    snd_old   = can_go && replaying;
    send      = snd_new || snd_old;
    tx_pay    = snd_new ? in_data : rbuf[snd_ptr[SEQ_W-1:0]];

    wr_ptr_n  = wr_ptr + PW'(snd_new);
    ack_ptr_n = ack_ptr + PW'(ack_vld);
    if (retry_vld)
      snd_ptr_n = ack_ptr + {1'b0, SEQ_W'(retry_seq - ack_ptr[SEQ_W-1:0])};
    else
      snd_ptr_n = snd_ptr + PW'(send);
    cred_n = cred + CW'(cr_ret) - CW'(send);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      snd_ptr   <= '0;
      ack_ptr   <= '0;
      cred      <= CW'(CREDITS);
      link_vld  <= 1'b0;
      link_seq  <= '0;
      link_flit <= '0;
    end else begin
      wr_ptr   <= wr_ptr_n;
      snd_ptr  <= snd_ptr_n;
      ack_ptr  <= ack_ptr_n;
      cred     <= cred_n;
      link_vld <= send;
      if (send) begin
        link_seq  <= snd_ptr[SEQ_W-1:0];
        link_flit <= {tx_pay, crc_of(tx_pay)};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (snd_new) rbuf[wr_ptr[SEQ_W-1:0]] <= in_data;
  end

  assign credits = cred;

  AST_NO_SEND_DRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cred == '0) |=> !link_vld); // R3
  AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cred <= CW'(CREDITS)); // R4
  AST_WINDOW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= PW'(DEPTH)); // R8
  AST_RETRY_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_vld |=> !link_vld); // R6

endmodule

// File: rtl/flit_rx_fifo.sv
module flit_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 72
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         vld,
  output logic [W-1:0] dout,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_idx, wr_idx_n, rd_idx, rd_idx_n;
  logic [NW-1:0] cnt, cnt_n;

  always_comb begin
    wr_idx_n = wr_idx;
    rd_idx_n = rd_idx;
    if (push) wr_idx_n = (wr_idx == AW'(DEPTH - 1)) ? '0 : wr_idx + 1'b1;
    if (pop)  rd_idx_n = (rd_idx == AW'(DEPTH - 1)) ? '0 : rd_idx + 1'b1;
    cnt_n = cnt + NW'(push) - NW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      cnt    <= '0;
    end else begin
      wr_idx <= wr_idx_n;
      rd_idx <= rd_idx_n;
      cnt    <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= din;
  end

  assign vld  = (cnt != '0);
  assign full = (cnt == NW'(DEPTH));
  assign dout = mem[rd_idx];

  AST_FIFO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop)); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !pop) |=> (vld && $stable(dout))); // R9

endmodule

// File: rtl/flit_rx.sv
module flit_rx
  import flit_link_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_vld,
  input  logic [SEQ_W-1:0]  link_seq,
  input  logic [FLIT_W-1:0] link_flit,
  output logic              ack_vld,
  output logic              retry_vld,
  output logic [SEQ_W-1:0]  retry_seq,
  output logic [1:0]        cr_ret,
  output logic              out_vld,
  output logic [PAY_W-1:0]  out_data,
  input  logic              out_rdy
);

  logic [SEQ_W-1:0] exp_seq, exp_seq_n;
  logic             discard, discard_n;
  logic [PAY_W-1:0] pay;
  logic             crc_ok, accept, bad_exp, drop, pop, full;

  always_comb begin
    pay     = link_flit[FLIT_W-1:CRC_W];
    crc_ok  = (crc_of(pay) == link_flit[CRC_W-1:0]);
    accept  = link_vld && crc_ok && (link_seq == exp_seq);
    bad_exp = link_vld && !crc_ok && (!discard || (link_seq == exp_seq));
    drop    = link_vld && !accept;
    pop     = out_vld && out_rdy;

    exp_seq_n = exp_seq + SEQ_W'(accept);
    if (accept)       discard_n = 1'b0;
    else if (bad_exp) discard_n = 1'b1;
    else              discard_n = discard;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_seq   <= '0;
      discard   <= 1'b0;
      ack_vld   <= 1'b0;
      retry_vld <= 1'b0;
      retry_seq <= '0;
      cr_ret    <= '0;
    end else begin
      exp_seq   <= exp_seq_n;
      discard   <= discard_n;
      ack_vld   <= accept;
      retry_vld <= bad_exp;
      if (bad_exp) retry_seq <= exp_seq;
      cr_ret    <= {1'b0, pop} + {1'b0, drop};
    end
  end

  flit_rx_fifo #(.DEPTH(DEPTH), .W(PAY_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .din   (pay),
    .pop   (pop),
    .vld   (out_vld),
    .dout  (out_data),
    .full  (full)
  );

  AST_RETRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_vld |-> $past(link_vld)); // R5
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_vld && retry_vld)); // R7

endmodule

// File: rtl/flit_link.sv
module flit_link
  import flit_link_pkg::*;
#(
  parameter int CREDITS = 4,
  parameter int SEQ_W   = 4,
  parameter int CW      = $clog2(CREDITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [PAY_W-1:0]  in_data,
  output logic              in_rdy,
  input  logic [FLIT_W-1:0] chan_flip,
  output logic              link_vld,
  output logic [SEQ_W-1:0]  link_seq,
  output logic [FLIT_W-1:0] link_flit,
  output logic [CW-1:0]     credits,
  output logic [1:0]        cr_ret,
  output logic              retry_vld,
  output logic [SEQ_W-1:0]  retry_seq,
  output logic              out_vld,
  output logic [PAY_W-1:0]  out_data,
  input  logic              out_rdy
);

  logic rst_meta, rst_sync;
  logic ack_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  flit_tx #(.CREDITS(CREDITS), .SEQ_W(SEQ_W), .CW(CW)) u_tx (
    .clk       (clk),
    .rst_n     (rst_sync),
    .in_vld    (in_vld),
    .in_data   (in_data),
    .in_rdy    (in_rdy),
    .ack_vld   (ack_vld),
    .retry_vld (retry_vld),
    .retry_seq (retry_seq),
    .cr_ret    (cr_ret),
    .link_vld  (link_vld),
    .link_seq  (link_seq),
    .link_flit (link_flit),
    .credits   (credits)
  );

  flit_rx #(.DEPTH(CREDITS), .SEQ_W(SEQ_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_sync),
    .link_vld  (link_vld),
    .link_seq  (link_seq),
    .link_flit (link_flit ^ chan_flip),
    .ack_vld   (ack_vld),
    .retry_vld (retry_vld),
    .retry_seq (retry_seq),
    .cr_ret    (cr_ret),
    .out_vld   (out_vld),
    .out_data  (out_data),
    .out_rdy   (out_rdy)
  );

endmodule

// File: tb/flit_link_tb.sv
module flit_link_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [71:0] in_data;
  logic        in_rdy;
  logic [79:0] chan_flip;
  logic        link_vld;
  logic [3:0]  link_seq;
  logic [79:0] link_flit;
  logic [2:0]  credits;
  logic [1:0]  cr_ret;
  logic        retry_vld;
  logic [3:0]  retry_seq;
  logic        out_vld;
  logic [71:0] out_data;
  logic        out_rdy;

  always #2.5 clk = ~clk;

  flit_link u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data), .in_rdy(in_rdy),
    .chan_flip(chan_flip), .link_vld(link_vld), .link_seq(link_seq),
    .link_flit(link_flit), .credits(credits), .cr_ret(cr_ret),
    .retry_vld(retry_vld), .retry_seq(retry_seq), .out_vld(out_vld),
    .out_data(out_data), .out_rdy(out_rdy)
  );

  int tests = 0;
  int fails = 0;

  logic [71:0] expq[$];
  logic [71:0] src[$];
  bit          have_prev = 0;
  logic [2:0]  prev_cred;
  logic [1:0]  prev_ret;
  logic [3:0]  last_seq = 4'd15;
  bit          pending = 0, retry_due = 0, expect_replay = 0, err_phase = 0;
  logic [3:0]  err_seq;
  bit          prev_stall = 0;
  logic [71:0] prev_data;
  int          cyc = 0;
  bit          dead = 0;

  function automatic logic [7:0] ref_crc(input logic [71:0] p);
    logic [79:0] v;
    v = {p, 8'h00};
    for (int i = 79; i >= 8; i--)
      if (v[i]) v[i-:9] = v[i-:9] ^ 9'h107;
    return v[7:0];
  endfunction

  function automatic logic [71:0] rnd_pay();
    logic [31:0] a, b, c;
    a = $urandom; b = $urandom; c = $urandom;
    return {c[7:0], b, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs once per cycle at the falling edge: check outputs, then drive inputs.
  task automatic cycle(input bit allow_in, input int rdy_pct);
    logic [2:0] ce;
    @(negedge clk);
    cyc++;
    if (have_prev) begin
      ce = prev_cred + 3'(prev_ret) - 3'(link_vld);
      chk(credits == ce, "R4 credit accounting", 80'(credits), 80'(ce));
      if (prev_cred == 3'd0) chk(!link_vld, "R3 no send at zero credits", 80'(link_vld), 80'd0);
    end
    if (credits == 3'd0) chk(!in_rdy, "R3 in_rdy low at zero credits", 80'(in_rdy), 80'd0);
    prev_cred = credits; prev_ret = cr_ret; have_prev = 1;

    if (link_vld) begin
      chk(link_flit[7:0] == ref_crc(link_flit[79:8]), "R1 crc field",
          80'(link_flit[7:0]), 80'(ref_crc(link_flit[79:8])));
      if (expect_replay) begin
        chk(link_seq == err_seq, "R6 replay starts at errored flit", 80'(link_seq), 80'(err_seq));
        expect_replay = 0;
        pending = 0;
      end else begin
        chk(link_seq == last_seq + 4'd1, "R8 sequence step", 80'(link_seq), 80'(last_seq + 4'd1));
      end
      last_seq = link_seq;
    end

    if (retry_due) begin
      chk(retry_vld && retry_seq == err_seq, "R5 retry after corrupt flit",
          80'({retry_vld, retry_seq}), 80'({1'b1, err_seq}));
      retry_due = 0;
    end else begin
      chk(!retry_vld, "R5 no spurious retry", 80'(retry_vld), 80'd0);
    end
    if (retry_vld) begin
      chk(!in_rdy, "R8 in_rdy low during retry", 80'(in_rdy), 80'd0);
      expect_replay = 1;
    end

    if (out_vld && prev_stall)
      chk(out_data == prev_data, "R9 output held while stalled", 80'(out_data), 80'(prev_data));
    else if (prev_stall)
      chk(out_vld, "R9 valid held while stalled", 80'(out_vld), 80'd1);

    // drive
    chan_flip = '0;
    if (link_vld && err_phase && !pending && !expect_replay && ($urandom % 6 == 0)) begin
      chan_flip = 80'd1 << ($urandom % 80);
      pending   = 1;
      retry_due = 1;
      err_seq   = link_seq;
    end

    out_rdy = (($urandom % 100) < rdy_pct);
    if (out_vld && out_rdy) begin
      if (expq.size() == 0)
        chk(0, "R7 unexpected delivery", 80'(out_data), 80'd0);
      else begin
        chk(out_data == expq[0], "R7 delivered payload order", 80'(out_data), 80'(expq[0]));
        void'(expq.pop_front());
      end
    end
    prev_stall = out_vld && !out_rdy;
    prev_data  = out_data;

    in_vld = allow_in && (src.size() > 0) && ($urandom % 4 != 0);
    in_data = in_vld ? src[0] : '0;
    if (in_vld && in_rdy) begin
      expq.push_back(src[0]);
      void'(src.pop_front());
    end
    if (cyc > 150000 && !dead) begin
      dead = 1;
      chk(0, "R7 watchdog expired", 80'(cyc), 80'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; in_vld = 0; in_data = '0; chan_flip = '0; out_rdy = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(credits == 3'd4, "R2 reset credits", 80'(credits), 80'd4);
    chk(!link_vld, "R2 reset link idle", 80'(link_vld), 80'd0);
    chk(!out_vld, "R2 reset output idle", 80'(out_vld), 80'd0);
    chk(in_rdy, "R2 reset in_rdy", 80'(in_rdy), 80'd1);

    // Directed: stalled consumer exhausts credits; corner payloads.
    src.push_back('0);
    src.push_back({72{1'b1}});
    for (int i = 0; i < 6; i++) src.push_back(rnd_pay());
    for (int i = 0; i < 20; i++) cycle(1, 0);
    chk(credits == 3'd0, "R3 credits exhausted", 80'(credits), 80'd0);
    chk(!link_vld, "R3 link quiet when dry", 80'(link_vld), 80'd0);

    // Random traffic with injected single-bit errors.
    for (int i = 0; i < 500; i++) src.push_back(rnd_pay());
    err_phase = 1;
    while (src.size() > 0 && !dead) cycle(1, 70);
    err_phase = 0;

    // Drain.
    while ((expq.size() > 0 || pending || expect_replay) && !dead) cycle(0, 100);
    for (int i = 0; i < 6; i++) cycle(0, 100);
    chk(credits == 3'd4, "R10 credits restored after drain", 80'(credits), 80'd4);
    chk(!out_vld && expq.size() == 0, "R7 nothing left undelivered", 80'(expq.size()), 80'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule